// File: doc/BRIEF.md
# Frame Skew Meter

The frame skew meter finds how far a frame-evaluation input lags the frame pulse. The result is given in half master-clock periods. Software reads the value and uses it to program the delay applied to each incoming serial stream. A measurement is started through a control input. The block arms while that input stays low for a whole frame, and it starts on the next rise of that input. The block then synchronises to the next frame boundary and measures one full frame. It reports a 12-bit result together with a done flag at the frame boundary after that.

A format select picks which edges are compared. In the active-low bus format, falling edges of the frame pulse and of the evaluation input are compared. In the active-high format, rising edges are compared. Both inputs are sampled on the rising clock edge. The evaluation input is also sampled on the falling edge, and this extra sample gives the half-period resolution.

Top module: `frame_skew_meter`

## Requirements
- R1: After reset, `done_o` is 0 and `offset_o` is 0.
- R2: A rise of `start_ctl_i` starts a measurement only after `start_ctl_i` has been low at ARM_EDGES (default 2) consecutive reference edges. With fewer, the rise is ignored: `done_o` and `offset_o` keep their values.
- R3: Holding `start_ctl_i` high starts no further measurement. It must return low and re-arm as in R2 before the next start.
- R4: `done_o` rises on the clock edge that samples the second reference edge after the start, and not earlier.
- R5: `done_o` is 0 from the clock edge that samples the start until the measurement completes.
- R6: While a measurement is in progress, `offset_o` keeps the previous result. It changes only when the measurement completes.
- R7: The result counts the half clock periods from the measured frame's reference edge to the first qualifying edge of `eval_i`. The measured frame is the one that opens with the first reference edge after the start. An input change in the half period after a rising clock edge counts as the even value 2k, and a change in the half period after a falling clock edge counts as 2k+1. Here k is the number of whole cycles after the frame pulse changed. A change in the same half period as the frame pulse reads 0.
- R8: With `fmt_gci_i` = 0, reference and qualifying edges are falling edges. With `fmt_gci_i` = 1, they are rising edges. Edges of the opposite direction on `eval_i` are not counted.
- R9: If the measured frame has no qualifying edge, the result is all ones (4095). Delays above 4095 also read 4095.
- R10: Only the first qualifying edge in the measured frame sets the result. Later edges in that frame are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frm_pulse_i | input | 1 | Frame pulse; its leading edge is the reference edge |
| eval_i | input | 1 | Frame-evaluation input whose skew is measured |
| fmt_gci_i | input | 1 | 0: falling-edge format, 1: rising-edge format |
| start_ctl_i | input | 1 | Measurement control bit; a low-then-high sequence starts a measurement |
| done_o | output | 1 | Measurement complete, result valid |
| offset_o | output | OFS_W (12) | Measured skew in half clock periods |

## Verification
The bench builds the block with its default parameters: a 12-bit result and two arming edges. Most frames are short, so many randomised measurements fit in each run, in both formats and at odd and even half-period positions. Two directed frames longer than 2048 cycles reach the top of the 12-bit range. One lands exactly at 4094 and one overruns into saturation. Further directed cases cover an inverted evaluation pulse, double pulses, a missing edge, too little arming and a control bit held high.

// File: rtl/fsk_pkg.sv
package fsk_pkg;

    // Measurement sequencer states
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,   // result stable, waiting for an armed start
        S_WAIT = 2'd1,   // started, waiting for the opening frame edge
        S_MEAS = 2'd2    // counting through the measured frame
    } fsk_state_e;

endpackage

// File: rtl/fsk_edge_sense.sv
module fsk_edge_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic gci_i,
    input  logic fp_i,
    input  logic fe_i,
    output logic ref_edge_o,
    output logic fe_lo_o,
    output logic fe_hi_o
);

    logic fp_p_q;   // frame pulse at previous rising edge
    logic fe_p_q;   // eval input at previous rising edge
    logic fe_n_q;   // eval input at the falling edge in between

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fp_p_q <= 1'b0;
            fe_p_q <= 1'b0;
        end else begin
            fp_p_q <= fp_i;
            fe_p_q <= fe_i;
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fe_n_q <= 1'b0;
        end else begin
            fe_n_q <= fe_i;
        end
    end

    always_comb begin
        if (gci_i) begin
            ref_edge_o = ~fp_p_q & fp_i;
            fe_lo_o    = ~fe_p_q & fe_n_q;
            fe_hi_o    = ~fe_n_q & fe_i;
        end else begin
            ref_edge_o = fp_p_q & ~fp_i;
            fe_lo_o    = fe_p_q & ~fe_n_q;
            fe_hi_o    = fe_n_q & ~fe_i;
        end
    end

    // R10: one clock period can hold at most one qualifying edge
    a_r10_one_edge_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fe_lo_o, fe_hi_o}));

endmodule

// File: rtl/fsk_arm.sv
module fsk_arm #(
    parameter int ARM_EDGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_i,
    input  logic ref_edge_i,
    input  logic idle_i,
    output logic start_o
);

    localparam int AW = $clog2(ARM_EDGES + 1);
    localparam logic [AW-1:0] ARM_FULL = AW'(ARM_EDGES);

    typedef struct packed {
        logic [AW-1:0] arm;
        logic          ctl;
    } arm_regs_t;

    arm_regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.ctl = ctl_i;
        if (ctl_i) begin
            r_d.arm = '0;
        end else if (ref_edge_i && (r_q.arm != ARM_FULL)) begin
            r_d.arm = r_q.arm + 1'b1;
        end
        start_o = ctl_i & ~r_q.ctl & (r_q.arm == ARM_FULL) & idle_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // R2: arming count never runs past its target
    a_r2_arm_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.arm <= ARM_FULL);

    // R3: a start follows a cycle in which the control bit was low
    a_r3_start_after_low: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> !$past(ctl_i));

endmodule

// File: rtl/frame_skew_meter.sv
module frame_skew_meter #(
    parameter int OFS_W     = 12,
    parameter int ARM_EDGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frm_pulse_i,
    input  logic             eval_i,
    input  logic             fmt_gci_i,
    input  logic             start_ctl_i,
    output logic             done_o,
    output logic [OFS_W-1:0] offset_o
);

    import fsk_pkg::*;

    localparam logic [OFS_W-1:0] OFS_MAX  = '1;
    localparam logic [OFS_W-1:0] OFS_TWO  = OFS_W'(2);
    localparam logic [OFS_W-1:0] CNT_STOP = OFS_MAX - 1'b1;

    typedef struct packed {
        fsk_state_e       state;
        logic [OFS_W-1:0] cnt;
        logic             found;
        logic [OFS_W-1:0] cap;
        logic             cfe;
        logic [OFS_W-1:0] res;
    } meter_regs_t;

    meter_regs_t r_d, r_q;

    logic             ref_edge;
    logic             fe_lo;
    logic             fe_hi;
    logic             start;
    logic             hit;
    logic [OFS_W-1:0] pos_now;
    logic [OFS_W-1:0] pos_edge;

    fsk_edge_sense u_sense (
        .clk        (clk),
        .rst_n      (rst_n),
        .gci_i      (fmt_gci_i),
        .fp_i       (frm_pulse_i),
        .fe_i       (eval_i),
        .ref_edge_o (ref_edge),
        .fe_lo_o    (fe_lo),
        .fe_hi_o    (fe_hi)
    );

    fsk_arm #(
        .ARM_EDGES (ARM_EDGES)
    ) u_arm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_i      (start_ctl_i),
        .ref_edge_i (ref_edge),
        .idle_i     (r_q.state == S_IDLE),
        .start_o    (start)
    );

    always_comb begin
        r_d = r_q;

        // half-period position of the current rising edge within the frame
        pos_now = ref_edge ? '0 : r_q.cnt;
        hit     = fe_lo | fe_hi;
        if (fe_lo) begin
            pos_edge = pos_now;
        end else if (pos_now == OFS_MAX) begin
            pos_edge = OFS_MAX;
        end else begin
            pos_edge = pos_now + 1'b1;
        end

        // free-running half-step counter, saturating
        if (ref_edge) begin
            r_d.cnt = OFS_TWO;
        end else if (r_q.cnt >= CNT_STOP) begin
            r_d.cnt = OFS_MAX;
        end else begin
            r_d.cnt = r_q.cnt + OFS_TWO;
        end

        unique case (r_q.state)
            S_IDLE: begin
                if (start) begin
                    r_d.state = S_WAIT;
                    r_d.cfe   = 1'b0;
                end
            end
            S_WAIT: begin
                if (ref_edge) begin
                    r_d.state = S_MEAS;
                    r_d.found = hit;
                    r_d.cap   = pos_edge;
                end
            end
            S_MEAS: begin
                if (ref_edge) begin
                    r_d.state = S_IDLE;
                    r_d.cfe   = 1'b1;
                    r_d.res   = r_q.found ? r_q.cap : OFS_MAX;
                    r_d.found = 1'b0;
                end else if (!r_q.found && hit) begin
                    r_d.found = 1'b1;
                    r_d.cap   = pos_edge;
                end
            end
            default: begin
                r_d.state = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: S_IDLE, cnt: '0, found: 1'b0,
                     cap: '0, cfe: 1'b0, res: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign done_o   = r_q.cfe;
    assign offset_o = r_q.res;

    // R5: done drops right after an accepted start
    a_r5_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !done_o);

    // R6: the result only moves when a measured frame closes
    a_r6_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state != S_MEAS) |=> $stable(offset_o));

    // R4: done rises only out of the measuring state
    a_r4_done_from_meas: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(r_q.state == S_MEAS));

    // R9: a frame without a qualifying edge reads all ones
    a_r9_no_edge_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == S_MEAS && ref_edge && !r_q.found) |=> (offset_o == OFS_MAX));

    // R7: the half-step count never decreases inside a frame
    a_r7_cnt_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_edge |=> (r_q.cnt >= $past(r_q.cnt)));

endmodule

// File: tb/frame_skew_meter_tb.sv
module frame_skew_meter_tb;

    localparam int CLK_PERIOD = 10;
    localparam int MAXV = 4095;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fp = 1'b1;
    logic        fe = 1'b1;
    logic        fmt = 1'b0;
    logic        sfe = 1'b0;
    logic        inv = 1'b0;
    logic        done;
    logic [11:0] ofs;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    frame_skew_meter u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .frm_pulse_i (fp),
        .eval_i      (fe),
        .fmt_gci_i   (fmt),
        .start_ctl_i (sfe),
        .done_o      (done),
        .offset_o    (ofs)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic idle_lvl();
        return fmt ? 1'b0 : 1'b1;
    endfunction

    function automatic logic fe_lvl(input int j, input int h, input int h2);
        logic act;
        act = (h >= 0 && (j == h || j == h + 1)) ||
              (h2 >= 0 && (j == h2 || j == h2 + 1));
        return (act ^ inv) ? ~idle_lvl() : idle_lvl();
    endfunction

    task automatic drive_frame(input int len, input int h, input int h2);
        for (int c = 0; c < len; c++) begin
            @(posedge clk); #1;
            fp = (c == 0) ? ~idle_lvl() : idle_lvl();
            fe = fe_lvl(2*c, h, h2);
            @(negedge clk); #1;
            fe = fe_lvl(2*c + 1, h, h2);
        end
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            fp = idle_lvl();
            fe = fe_lvl(-5, -1, -1);
        end
    endtask

    function automatic int expect_of(input int h, input int h2);
        int first;
        first = h;
        if (first < 0 || (h2 >= 0 && h2 < first)) first = h2;
        if (first < 0) return MAXV;
        if (inv) first = first + 2;
        return (first > MAXV) ? MAXV : first;
    endfunction

    task automatic run_meas(input string req, input logic f, input logic iv,
                            input int len, input int h, input int h2);
        int prev;
        int exp;
        gap(1);
        fmt = f;
        inv = iv;
        gap(2);
        sfe = 1'b0;
        prev = int'(ofs);
        drive_frame(8, -1, -1);
        drive_frame(8, -1, -1);
        @(posedge clk); #1;
        sfe = 1'b1;
        fp = idle_lvl();
        gap(2);
        chk("R5 done low after start", int'(done), 0);
        drive_frame(len, h, h2);
        chk("R6 result held during measurement", int'(ofs), prev);
        drive_frame(1, -1, -1);
        chk("R4 done not before closing edge", int'(done), 0);
        gap(1);
        chk("R4 done at second edge after start", int'(done), 1);
        exp = expect_of(h, h2);
        chk(req, int'(ofs), exp);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int held;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset done", int'(done), 0);
        chk("R1 reset offset", int'(ofs), 0);
        rst_n = 1'b1;
        gap(2);
        chk("R1 done after reset release", int'(done), 0);

        // directed half-step corners, both formats
        run_meas("R7 offset zero", 1'b0, 1'b0, 12, 0, -1);
        run_meas("R7 offset one", 1'b1, 1'b0, 12, 1, -1);
        run_meas("R7 late odd offset", 1'b0, 1'b0, 12, 21, -1);
        run_meas("R10 first edge wins", 1'b1, 1'b0, 20, 5, 20);
        run_meas("R10 first edge wins odd", 1'b0, 1'b0, 20, 9, 30);
        run_meas("R8 opposite edge ignored st", 1'b0, 1'b1, 16, 6, -1);
        run_meas("R8 opposite edge ignored gci", 1'b1, 1'b1, 16, 11, -1);
        run_meas("R9 no edge all ones", 1'b0, 1'b0, 14, -1, -1);
        run_meas("R7 top of range", 1'b1, 1'b0, 2100, 4094, -1);
        run_meas("R9 saturation", 1'b0, 1'b0, 2200, 4200, -1);

        // randomised measurements
        for (int k = 0; k < 14; k++) begin
            int len;
            int h;
            logic f;
            len = 10 + int'($urandom % 40);
            h   = int'($urandom % (2*len - 2));
            f   = logic'($urandom % 2);
            run_meas("R7 R8 random offset", f, 1'b0, len, h, -1);
        end

        // R2: only one low frame before the rise, no start
        held = int'(ofs);
        gap(1);
        sfe = 1'b0;
        drive_frame(8, -1, -1);
        gap(2);
        @(posedge clk); #1;
        sfe = 1'b1;
        gap(3);
        chk("R2 unarmed rise ignored done", int'(done), 1);
        drive_frame(10, 3, -1);
        drive_frame(10, 7, -1);
        gap(2);
        chk("R2 unarmed rise ignored offset", int'(ofs), held);

        // R3: control held high across many frames
        drive_frame(10, 2, -1);
        drive_frame(10, 4, -1);
        drive_frame(10, 6, -1);
        gap(2);
        chk("R3 held high done stays", int'(done), 1);
        chk("R3 held high offset stays", int'(ofs), held);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule